// File: doc/BRIEF.md
# Event Status and Status Byte Summary

This block keeps the device's standard event register and its enable mask, and it builds the status byte that a host polls. Device logic reports errors and completions as single-cycle pulses. Each pulse sets a sticky bit that stays set until the host reads the register or issues a clear-status. A read returns the register and empties it in the same step. The enable mask chooses which event bits feed the event summary bit of the status byte.

The status byte also carries two group summaries and two flags from neighbouring blocks: queue not empty and output message available. All of these pass through without being registered.

Every port is a plain control or status pin. The read strobe has no handshake: a read is always accepted, the data is valid in the cycle of the strobe, and there is no back-pressure. The mask port is a plain write-enable with continuous read-back.

Top module: `evt_status_hub`

## Requirements
- R1: A pulse on `evt_set_i` bit k, for k in {0 operation complete, 2 query error, 3 device error, 4 execution error, 5 command error}, sets event bit k on the next clock edge. Input bits 1, 6 and 7 are ignored, and event bits 1 and 6 always read 0.
- R2: Event bit 7 (power-on) is set by the first clock edge after `rst_n` deasserts.
- R3: `evt_rd_data_o` shows the event register. A cycle with `evt_rd_i` high clears the register at that clock edge.
- R4: A pulse that arrives in the same cycle as a read or a clear-status is kept, so its bit is set after the edge.
- R5: Event bits can only be set by pulses. Once set, a bit holds until a read or a clear-status.
- R6: `stb_o` bit 5 is the OR of (event register AND enable mask). It is combinational in the current cycle, so a mask of 0x00 keeps it low and a mask of 0xFF makes it follow any set event bit.
- R7: `mask_wr_i` loads `mask_wdata_i` into the mask at the clock edge. `mask_rdata_o` returns the mask, and its reset value is 0x00.
- R8: `cls_i` clears the event register at the clock edge and leaves the mask unchanged.
- R9: In `stb_o`, bit 2 is `queue_nempty_i`, bit 3 is `ques_sum_i`, bit 4 is `msg_avail_i` and bit 7 is `oper_sum_i`. Bits 0, 1 and 6 are 0.
- R10: While `rst_n` is low, the event register and the mask are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_i | input | 8 | Single-cycle event set pulses, one per bit |
| evt_rd_i | input | 1 | Read strobe; clears the event register at the edge |
| evt_rd_data_o | output | 8 | Current event register value |
| cls_i | input | 1 | Clear-status; wipes the event register |
| mask_wr_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 8 | Enable mask write data |
| mask_rdata_o | output | 8 | Enable mask read-back |
| ques_sum_i | input | 1 | Questionable group summary |
| oper_sum_i | input | 1 | Operation group summary |
| queue_nempty_i | input | 1 | Error/event queue not empty |
| msg_avail_i | input | 1 | Output message available |
| stb_o | output | 8 | Status byte |

## Verification
The bench drives a pulse and a read into the same cycle. A design that lets the clear win would lose the new bit. It also drives all-ones on the pulse input, so a design that passes unused or power-on inputs through would show bits 1, 6 or 7. The bench checks that a clear-status leaves the mask intact, which a design that resets both registers together would fail. It also checks that the summary bit follows the mask with no extra cycle, which a registered summary would show one cycle late. Finally it checks that the power-on bit appears exactly one edge after reset release and that a read then removes it.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;
  localparam int EVT_W = 8;
  localparam int STB_W = 8;
  // event register bit positions
  localparam int EB_OPC = 0;
  localparam int EB_QRY = 2;
  localparam int EB_DEV = 3;
  localparam int EB_EXE = 4;
  localparam int EB_CMD = 5;
  localparam int EB_PON = 7;
  // status byte bit positions
  localparam int SB_QUE  = 2;
  localparam int SB_QUES = 3;
  localparam int SB_MSG  = 4;
  localparam int SB_ESB  = 5;
  localparam int SB_OPER = 7;

  localparam logic [EVT_W-1:0] PULSE_MASK =
      EVT_W'((1 << EB_OPC) | (1 << EB_QRY) | (1 << EB_DEV) | (1 << EB_EXE) | (1 << EB_CMD));
  localparam logic [EVT_W-1:0] PON_BIT = EVT_W'(1 << EB_PON);
endpackage

// File: rtl/evt_latch.sv
module evt_latch
  import evt_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_i,
  input  logic             rd_clr_i,
  input  logic             cls_i,
  output logic [EVT_W-1:0] evt_o
);
  logic [EVT_W-1:0] evt_q, evt_d, kept;
  logic             por_pend_q;

  always_comb begin
    kept  = (rd_clr_i || cls_i) ? '0 : evt_q;
    evt_d = kept | (set_i & PULSE_MASK) | (por_pend_q ? PON_BIT : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q      <= '0;
      por_pend_q <= 1'b1;
    end else begin
      evt_q      <= evt_d;
      por_pend_q <= 1'b0;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg
  import evt_stat_pkg::*;
#(
  parameter logic [EVT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [EVT_W-1:0] wdata_i,
  output logic [EVT_W-1:0] mask_o
);
  logic [EVT_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= RST_VAL;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/stb_build.sv
module stb_build
  import evt_stat_pkg::*;
(
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] mask_i,
  input  logic             queue_nempty_i,
  input  logic             ques_i,
  input  logic             msg_i,
  input  logic             oper_i,
  output logic [STB_W-1:0] stb_o
);
  always_comb begin
    stb_o          = '0;
    stb_o[SB_QUE]  = queue_nempty_i;
    stb_o[SB_QUES] = ques_i;
    stb_o[SB_MSG]  = msg_i;
    stb_o[SB_ESB]  = |(evt_i & mask_i);
    stb_o[SB_OPER] = oper_i;
  end
endmodule

// File: rtl/evt_status_hub.sv
module evt_status_hub
  import evt_stat_pkg::*;
#(
  parameter logic [EVT_W-1:0] MASK_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_set_i,
  input  logic             evt_rd_i,
  output logic [EVT_W-1:0] evt_rd_data_o,
  input  logic             cls_i,
  input  logic             mask_wr_i,
  input  logic [EVT_W-1:0] mask_wdata_i,
  output logic [EVT_W-1:0] mask_rdata_o,
  input  logic             ques_sum_i,
  input  logic             oper_sum_i,
  input  logic             queue_nempty_i,
  input  logic             msg_avail_i,
  output logic [STB_W-1:0] stb_o
);
  logic [EVT_W-1:0] evt_w, mask_w;

  evt_latch u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set_i),
    .rd_clr_i(evt_rd_i), .cls_i(cls_i), .evt_o(evt_w)
  );

  evt_mask_reg #(.RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(mask_wr_i),
    .wdata_i(mask_wdata_i), .mask_o(mask_w)
  );

  stb_build u_stb (
    .evt_i(evt_w), .mask_i(mask_w), .queue_nempty_i(queue_nempty_i),
    .ques_i(ques_sum_i), .msg_i(msg_avail_i), .oper_i(oper_sum_i),
    .stb_o(stb_o)
  );

  assign evt_rd_data_o = evt_w;
  assign mask_rdata_o  = mask_w;
endmodule

// File: rtl/evt_status_hub_chk.sv
module evt_status_hub_chk
  import evt_stat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_W-1:0] evt_set_i,
  input logic             evt_rd_i,
  input logic [EVT_W-1:0] evt_rd_data_o,
  input logic             cls_i,
  input logic             mask_wr_i,
  input logic [EVT_W-1:0] mask_rdata_o,
  input logic             queue_nempty_i,
  input logic             oper_sum_i,
  input logic [STB_W-1:0] stb_o
);
  logic started_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  AST_SET_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_rd_data_o & $past(evt_set_i & PULSE_MASK)) == $past(evt_set_i & PULSE_MASK))); // R4
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_data_o[1] == 1'b0) && (evt_rd_data_o[6] == 1'b0)); // R1
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    started_q && (evt_rd_i || cls_i) && ((evt_set_i & PULSE_MASK) == '0) |=> evt_rd_data_o == '0); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_rd_i && !cls_i |=> ((evt_rd_data_o & $past(evt_rd_data_o)) == $past(evt_rd_data_o))); // R5
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_rdata_o == '0) |-> !stb_o[SB_ESB]); // R6
  AST_CLS_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cls_i && !mask_wr_i |=> $stable(mask_rdata_o)); // R8
  AST_STB_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_o[0] && !stb_o[1] && !stb_o[6] && (stb_o[SB_QUE] == queue_nempty_i)
    && (stb_o[SB_OPER] == oper_sum_i)); // R9
endmodule

bind evt_status_hub evt_status_hub_chk u_chk (.*);

// File: tb/evt_status_hub_bench.sv
module evt_status_hub_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_set_i = '0;
  logic       evt_rd_i = 1'b0;
  logic [7:0] evt_rd_data_o;
  logic       cls_i = 1'b0;
  logic       mask_wr_i = 1'b0;
  logic [7:0] mask_wdata_i = '0;
  logic [7:0] mask_rdata_o;
  logic       ques_sum_i = 1'b0, oper_sum_i = 1'b0, queue_nempty_i = 1'b0, msg_avail_i = 1'b0;
  logic [7:0] stb_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_status_hub u_evt_status_hub (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic pulse(logic [7:0] v);
    @(negedge clk); evt_set_i = v; tick(); evt_set_i = '0;
  endtask

  task automatic do_read();
    @(negedge clk); evt_rd_i = 1'b1; tick(); evt_rd_i = 1'b0;
  endtask

  task automatic wr_mask(logic [7:0] v);
    @(negedge clk); mask_wr_i = 1'b1; mask_wdata_i = v; tick(); mask_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 evt in reset", evt_rd_data_o, 8'h00);
    chk("R10 mask in reset", mask_rdata_o, 8'h00);
    @(negedge clk); rst_n = 1'b1; tick();
    chk("R2 power-on bit", evt_rd_data_o, 8'h80);
    chk("R6 mask zero summary", stb_o, 8'h00);
  endtask

  task automatic t_read_clear();
    chk("R3 data before read", evt_rd_data_o, 8'h80);
    do_read();
    chk("R3 cleared by read", evt_rd_data_o, 8'h00);
  endtask

  task automatic t_set_bits();
    pulse(8'hFF);
    chk("R1 only defined bits set", evt_rd_data_o, 8'h3D);
    do_read();
    pulse(8'h08);
    chk("R1 single bit 3", evt_rd_data_o, 8'h08);
    do_read();
  endtask

  task automatic t_sticky();
    pulse(8'h04);
    repeat (3) tick();
    chk("R5 bit holds", evt_rd_data_o, 8'h04);
    do_read();
    chk("R5 no spontaneous set", evt_rd_data_o, 8'h00);
  endtask

  task automatic t_mask();
    wr_mask(8'h10);
    chk("R7 mask readback", mask_rdata_o, 8'h10);
    chk("R6 no event no summary", stb_o & 8'h20, 8'h00);
    pulse(8'h01);
    chk("R6 masked bit no summary", stb_o & 8'h20, 8'h00);
    pulse(8'h10);
    chk("R6 enabled bit summary", stb_o & 8'h20, 8'h20);
    do_read();
    chk("R6 summary drops with read", stb_o & 8'h20, 8'h00);
    pulse(8'h01);
    @(negedge clk); mask_wr_i = 1'b1; mask_wdata_i = 8'hFF; tick(); mask_wr_i = 1'b0;
    chk("R6 mask FF follows event", stb_o & 8'h20, 8'h20);
    do_read();
  endtask

  task automatic t_same_cycle();
    pulse(8'h08);
    @(negedge clk); evt_rd_i = 1'b1; evt_set_i = 8'h20; tick();
    evt_rd_i = 1'b0; evt_set_i = '0;
    chk("R4 pulse kept over read", evt_rd_data_o, 8'h20);
    do_read();
  endtask

  task automatic t_cls();
    wr_mask(8'hA5);
    pulse(8'h3C);
    @(negedge clk); cls_i = 1'b1; tick(); cls_i = 1'b0;
    chk("R8 cls clears events", evt_rd_data_o, 8'h00);
    chk("R8 cls keeps mask", mask_rdata_o, 8'hA5);
    pulse(8'h04);
    @(negedge clk); cls_i = 1'b1; evt_set_i = 8'h01; tick();
    cls_i = 1'b0; evt_set_i = '0;
    chk("R4 pulse kept over cls", evt_rd_data_o, 8'h01);
    do_read();
    wr_mask(8'h00);
  endtask

  task automatic t_stb();
    queue_nempty_i = 1'b1; #1; chk("R9 queue bit2", stb_o, 8'h04);
    queue_nempty_i = 1'b0; ques_sum_i = 1'b1; #1; chk("R9 ques bit3", stb_o, 8'h08);
    ques_sum_i = 1'b0; msg_avail_i = 1'b1; #1; chk("R9 msg bit4", stb_o, 8'h10);
    msg_avail_i = 1'b0; oper_sum_i = 1'b1; #1; chk("R9 oper bit7", stb_o, 8'h80);
    queue_nempty_i = 1'b1; ques_sum_i = 1'b1; msg_avail_i = 1'b1; #1;
    chk("R9 all flags", stb_o, 8'h9C);
    queue_nempty_i = 1'b0; ques_sum_i = 1'b0; msg_avail_i = 1'b0; oper_sum_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_read_clear();
    t_set_bits();
    t_sticky();
    t_mask();
    t_same_cycle();
    t_cls();
    t_stb();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule